// File: doc/BRIEF.md
# Translation Table Miss-Refill Engine

This sequencer services a miss in a small translation buffer. The translation table sits in memory at a fixed base address. When a miss is requested, the engine holds the requesting access off by keeping `busy` high. It first saves all 16 buffer entries into the head of the table, because the buffer reorders its entries as it is used. It then walks the table two entries per clock, looking for the missing virtual page.

On a match, the engine moves the found entry to slot 0 by sliding the earlier slots up one place. It then refills the whole buffer from table slots 0 to 15 and pulses `done`, which releases the access. If the walk reaches an end-marked entry or the table length without a match, the engine pulses `fault` instead and leaves the buffer untouched. Page-fault service itself is handled elsewhere.

The table memory port has two read addresses with one-cycle read latency and one write address. The buffer is reached through a bulk port: a combinational read by index and a one-entry-per-cycle write. `last_cycles` reports the length of the most recent refill so that its overhead can be measured.

Top module: `tt_refill_engine`

## Requirements
- R1: While idle, a high `miss_req` at a clock edge is accepted with its `miss_vpn`. `busy` is high from the next cycle through the cycle in which `done` or `fault` pulses, and is low in the cycle after that pulse.
- R2: `miss_req` is ignored while `busy` is high. No second refill starts, and the page being sought does not change.
- R3: The first 16 busy cycles write buffer entries 0..15, in index order, to table slots 0..15 at addresses `BASE_ADDR`+0..15. No table write ever leaves the range `BASE_ADDR` to `BASE_ADDR+TBL_LEN-1`.
- R4: The table is walked from slot 0 upward, two slots per cycle. When both slots of a pair match, the lower-indexed slot is taken. The first match in index order is always the one used.
- R5: A table entry is 17 bits: bit 16 is the end mark, bits 15:8 are the virtual page and bits 7:0 are the physical page. An end-marked entry never matches, and no slot past it is considered.
- R6: On a match at slot m, the old contents of slots 0..m-1 move to slots 1..m and the matched entry is written to slot 0. All other slots keep their saved contents.
- R7: After the move, buffer entries 0..15 are reloaded from table slots 0..15. `done` then pulses for exactly one cycle.
- R8: If no match exists before an end mark or before slot `TBL_LEN`, `fault` pulses for exactly one cycle. The buffer is left unchanged, and the table holds the saved entries with no move applied.
- R9: `last_cycles` gives the busy cycle count of the last refill. For a hit at slot m it is 16 + (m/2 + 2) + (1 if m = 0, else m + 2) + 17 + 1. For a fault whose walk stops in pair k it is 16 + (k + 2) + 1, where k = e/2 for an end mark at slot e, and k = (TBL_LEN-1)/2 when the length runs out.
- R10: After reset, `busy`, `done` and `fault` are low and `last_cycles` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_req | input | 1 | Miss request, sampled while idle |
| miss_vpn | input | 8 | Virtual page that missed |
| busy | output | 1 | Refill in progress; the access stays suspended |
| done | output | 1 | One-cycle pulse: buffer refilled, access may resume |
| fault | output | 1 | One-cycle pulse: page not in the table |
| last_cycles | output | CNT_W | Busy cycle count of the latest refill |
| mem_rd_en | output | 1 | Table read strobe; data arrives one cycle later |
| mem_rd_addr0 | output | ADDR_W | First read address |
| mem_rd_addr1 | output | ADDR_W | Second read address |
| mem_rd_data0 | input | 17 | Entry read from the first address |
| mem_rd_data1 | input | 17 | Entry read from the second address |
| mem_wr_en | output | 1 | Table write strobe |
| mem_wr_addr | output | ADDR_W | Table write address |
| mem_wr_data | output | 17 | Table write entry |
| buf_rd_idx | output | 4 | Buffer entry selected for saving |
| buf_rd_data | input | 17 | Buffer entry at `buf_rd_idx` (combinational) |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_idx | output | 4 | Buffer entry being reloaded |
| buf_wr_data | output | 17 | Entry written into the buffer |

## Verification
Hits are tried at slot 0, at the last saved slot 15, at an odd slot deep in the table, and on a pair whose two slots hold the same page. Together these separate an off-by-one in the pair walk, the lower-slot priority, and the shift length of the move, each through the final table image and the reported cycle count. Before each run the head of the table is preloaded with stale entries that hold the faulting page, so a missing or misaddressed save turns a fault into a hit. The fault cases cover a page placed just past an end mark, an end-marked entry carrying the sought page, and a table with no end mark at all. These distinguish end-mark handling from the length limit. A repeated request in mid-refill checks that a busy engine neither restarts nor changes its target.

// File: rtl/tt_refill_pkg.sv
package tt_refill_pkg;

    localparam int VPN_W = 8;
    localparam int PPN_W = 8;

    typedef struct packed {
        logic             tail;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tte_t;

    localparam int TTE_W = $bits(tte_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_SCAN,
        ST_SHIFT,
        ST_LOAD,
        ST_DONE,
        ST_FLT
    } rf_state_e;

    function automatic logic tte_hits(input tte_t e, input logic [VPN_W-1:0] want);
        return !e.tail && (e.vpn == want);
    endfunction

endpackage

// File: rtl/tt_pair_probe.sv
module tt_pair_probe
    import tt_refill_pkg::*;
#(
    parameter int TBL_LEN = 40,
    parameter int IDX_W   = 6
) (
    input  tte_t             lo_e,
    input  tte_t             hi_e,
    input  logic [VPN_W-1:0] want,
    input  logic [IDX_W-1:0] base,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output tte_t             hit_e,
    output logic             stop
);
    logic hi_ok, lo_m, hi_m;

    always_comb begin
        hi_ok   = (int'(base) + 1 < TBL_LEN) && !lo_e.tail;
        lo_m    = tte_hits(lo_e, want);
        hi_m    = hi_ok && tte_hits(hi_e, want);
        hit     = lo_m || hi_m;
        hit_idx = lo_m ? base : base + IDX_W'(1);
        hit_e   = lo_m ? lo_e : hi_e;
        stop    = lo_e.tail || (hi_ok && hi_e.tail) || (int'(base) + 2 >= TBL_LEN);
    end
endmodule

// File: rtl/tt_busy_meter.sv
module tt_busy_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             busy,
    input  logic             finish,
    output logic [CNT_W-1:0] last
);
    logic [CNT_W-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= '0;
            last <= '0;
        end else begin
            if (start)     cyc <= '0;
            else if (busy) cyc <= cyc + CNT_W'(1);
            if (finish)    last <= cyc + CNT_W'(1);
        end
    end

    // R9
    meter_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cyc == '0));
endmodule

// File: rtl/tt_refill_engine.sv
module tt_refill_engine
    import tt_refill_pkg::*;
#(
    parameter int BUF_N     = 16,
    parameter int TBL_LEN   = 40,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 16,
    parameter int CNT_W     = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      miss_req,
    input  logic [7:0]                miss_vpn,
    output logic                      busy,
    output logic                      done,
    output logic                      fault,
    output logic [CNT_W-1:0]          last_cycles,
    output logic                      mem_rd_en,
    output logic [ADDR_W-1:0]         mem_rd_addr0,
    output logic [ADDR_W-1:0]         mem_rd_addr1,
    input  logic [16:0]               mem_rd_data0,
    input  logic [16:0]               mem_rd_data1,
    output logic                      mem_wr_en,
    output logic [ADDR_W-1:0]         mem_wr_addr,
    output logic [16:0]               mem_wr_data,
    output logic [$clog2(BUF_N)-1:0]  buf_rd_idx,
    input  logic [16:0]               buf_rd_data,
    output logic                      buf_wr_en,
    output logic [$clog2(BUF_N)-1:0]  buf_wr_idx,
    output logic [16:0]               buf_wr_data
);
    localparam int BUF_IW = $clog2(BUF_N);
    localparam int IDX_W  = $clog2(TBL_LEN + 2);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);
    localparam logic [IDX_W-1:0]  I_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0]  I_TWO  = IDX_W'(2);

    rf_state_e          state;
    logic [VPN_W-1:0]   want;
    logic [BUF_IW-1:0]  save_i;
    logic [IDX_W-1:0]   scan_ptr, scan_base;
    logic               scan_pend;
    tte_t               hit_ent;
    logic [IDX_W-1:0]   mv_ptr, mv_wj;
    logic               mv_pend;
    logic [BUF_IW:0]    ld_ptr;
    logic [BUF_IW-1:0]  ld_wi;
    logic               ld_pend;

    tte_t               rd0_e, rd1_e, p_ent;
    logic               p_hit, p_stop;
    logic [IDX_W-1:0]   p_idx;

    assign rd0_e = tte_t'(mem_rd_data0);
    assign rd1_e = tte_t'(mem_rd_data1);

    tt_pair_probe #(.TBL_LEN(TBL_LEN), .IDX_W(IDX_W)) probe_i (
        .lo_e(rd0_e), .hi_e(rd1_e), .want(want), .base(scan_base),
        .hit(p_hit), .hit_idx(p_idx), .hit_e(p_ent), .stop(p_stop)
    );

    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_DONE);
    assign fault = (state == ST_FLT);

    tt_busy_meter #(.CNT_W(CNT_W)) meter_i (
        .clk(clk), .rst(rst),
        .start(!busy && miss_req), .busy(busy), .finish(done || fault),
        .last(last_cycles)
    );

    // memory and buffer port drive
    always_comb begin
        mem_rd_en    = 1'b0;
        mem_rd_addr0 = '0;
        mem_rd_addr1 = '0;
        mem_wr_en    = 1'b0;
        mem_wr_addr  = '0;
        mem_wr_data  = '0;
        buf_rd_idx   = save_i;
        buf_wr_en    = 1'b0;
        buf_wr_idx   = ld_wi;
        buf_wr_data  = mem_rd_data0;
        unique case (state)
            ST_SAVE: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = BASE_A + ADDR_W'(save_i);
                mem_wr_data = buf_rd_data;
            end
            ST_SCAN: begin
                if (int'(scan_ptr) < TBL_LEN) begin
                    mem_rd_en    = 1'b1;
                    mem_rd_addr0 = BASE_A + ADDR_W'(scan_ptr);
                    mem_rd_addr1 = BASE_A + ADDR_W'(scan_ptr) + A_ONE;
                end
            end
            ST_SHIFT: begin
                if (mv_pend) begin
                    mem_wr_en   = 1'b1;
                    mem_wr_addr = BASE_A + ADDR_W'(mv_wj) + A_ONE;
                    mem_wr_data = mem_rd_data0;
                end else if (mv_ptr == '0) begin
                    mem_wr_en   = 1'b1;
                    mem_wr_addr = BASE_A;
                    mem_wr_data = hit_ent;
                end
                if (mv_ptr != '0) begin
                    mem_rd_en    = 1'b1;
                    mem_rd_addr0 = BASE_A + ADDR_W'(mv_ptr - I_ONE);
                    mem_rd_addr1 = mem_rd_addr0;
                end
            end
            ST_LOAD: begin
                buf_wr_en = ld_pend;
                if (int'(ld_ptr) < BUF_N) begin
                    mem_rd_en    = 1'b1;
                    mem_rd_addr0 = BASE_A + ADDR_W'(ld_ptr);
                    mem_rd_addr1 = mem_rd_addr0;
                end
            end
            default: ;
        endcase
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            want      <= '0;
            save_i    <= '0;
            scan_ptr  <= '0;
            scan_base <= '0;
            scan_pend <= 1'b0;
            hit_ent   <= '0;
            mv_ptr    <= '0;
            mv_wj     <= '0;
            mv_pend   <= 1'b0;
            ld_ptr    <= '0;
            ld_wi     <= '0;
            ld_pend   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (miss_req) begin
                        want   <= miss_vpn;
                        save_i <= '0;
                        state  <= ST_SAVE;
                    end
                end
                ST_SAVE: begin
                    save_i <= save_i + BUF_IW'(1);
                    if (save_i == BUF_IW'(BUF_N - 1)) begin
                        scan_ptr  <= '0;
                        scan_pend <= 1'b0;
                        state     <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (int'(scan_ptr) < TBL_LEN) begin
                        scan_pend <= 1'b1;
                        scan_base <= scan_ptr;
                        scan_ptr  <= scan_ptr + I_TWO;
                    end else begin
                        scan_pend <= 1'b0;
                    end
                    if (scan_pend) begin
                        if (p_hit) begin
                            hit_ent <= p_ent;
                            mv_ptr  <= p_idx;
                            mv_pend <= 1'b0;
                            state   <= ST_SHIFT;
                        end else if (p_stop) begin
                            state <= ST_FLT;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (mv_ptr != '0) begin
                        mv_ptr  <= mv_ptr - I_ONE;
                        mv_wj   <= mv_ptr - I_ONE;
                        mv_pend <= 1'b1;
                    end else begin
                        mv_pend <= 1'b0;
                        if (!mv_pend) begin
                            ld_ptr  <= '0;
                            ld_pend <= 1'b0;
                            state   <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (int'(ld_ptr) < BUF_N) begin
                        ld_ptr  <= ld_ptr + (BUF_IW+1)'(1);
                        ld_wi   <= ld_ptr[BUF_IW-1:0];
                        ld_pend <= 1'b1;
                    end else begin
                        ld_pend <= 1'b0;
                        if (ld_pend) state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                ST_FLT:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && miss_req) |=> busy);

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !fault) |=> busy);

    // R2
    ignore_req_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(want));

    // R3
    wr_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (int'(mem_wr_addr) >= BASE_ADDR && int'(mem_wr_addr) < BASE_ADDR + TBL_LEN));

    // R7
    reload_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(buf_wr_en));

    // R8
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!fault && !busy));

    // R8
    no_reload_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> !$past(buf_wr_en));

    // R1
    excl_end_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));
endmodule

// File: tb/tt_refill_engine_tb_top.sv
module tt_refill_engine_tb_top;
    import tt_refill_pkg::*;

    localparam int BUF_N     = 16;
    localparam int TBL_LEN   = 40;
    localparam int ADDR_W    = 8;
    localparam int BASE_ADDR = 16;
    localparam int CNT_W     = 12;
    localparam int MEM_N     = 1 << ADDR_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              miss_req;
    logic [7:0]        miss_vpn;
    logic              busy, done, fault;
    logic [CNT_W-1:0]  last_cycles;
    logic              mem_rd_en, mem_wr_en, buf_wr_en;
    logic [ADDR_W-1:0] mem_rd_addr0, mem_rd_addr1, mem_wr_addr;
    logic [16:0]       mem_rd_data0, mem_rd_data1, mem_wr_data, buf_rd_data, buf_wr_data;
    logic [3:0]        buf_rd_idx, buf_wr_idx;

    tt_refill_engine #(
        .BUF_N(BUF_N), .TBL_LEN(TBL_LEN), .ADDR_W(ADDR_W),
        .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst(rst), .miss_req(miss_req), .miss_vpn(miss_vpn),
        .busy(busy), .done(done), .fault(fault), .last_cycles(last_cycles),
        .mem_rd_en(mem_rd_en), .mem_rd_addr0(mem_rd_addr0), .mem_rd_addr1(mem_rd_addr1),
        .mem_rd_data0(mem_rd_data0), .mem_rd_data1(mem_rd_data1),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data)
    );

    // table memory and translation buffer models
    logic [16:0] mem    [0:MEM_N-1];
    logic [16:0] bm     [0:BUF_N-1];
    logic [16:0] st_mem [0:MEM_N-1];
    logic [16:0] st_bm  [0:BUF_N-1];
    logic [16:0] exp_tbl[0:TBL_LEN-1];
    logic [16:0] exp_bm [0:BUF_N-1];
    logic        load_stage = 1'b0;

    assign buf_rd_data = bm[buf_rd_idx];

    always @(posedge clk) begin
        if (load_stage) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= st_mem[i];
            for (int i = 0; i < BUF_N; i++) bm[i]  <= st_bm[i];
        end else begin
            if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
            if (mem_rd_en) begin
                mem_rd_data0 <= mem[mem_rd_addr0];
                mem_rd_data1 <= mem[mem_rd_addr1];
            end
            if (buf_wr_en) bm[buf_wr_idx] <= buf_wr_data;
        end
    end

    int total = 0;
    int bad   = 0;
    int n_mon = 0;
    int n_exp = 0;

    typedef struct {
        bit flt;
        int cyc;
    } exp_item_t;
    exp_item_t sq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [16:0] mk(input bit t, input logic [7:0] v, input logic [7:0] p);
        return {t, v, p};
    endfunction

    // default image: stale head slots carry page F0 so a skipped save would hit
    task automatic setup_default();
        for (int i = 0; i < MEM_N; i++) st_mem[i] = mk(1'b0, 8'hF0, 8'hEE);
        for (int i = BUF_N; i < TBL_LEN; i++)
            st_mem[BASE_ADDR + i] = mk(1'b0, 8'(i), 8'(8'hA0 + i));
        for (int i = 0; i < BUF_N; i++) st_bm[i] = mk(1'b0, 8'(8'h80 + i), 8'(i));
    endtask

    task automatic apply_stage();
        @(negedge clk);
        load_stage = 1'b1;
        @(negedge clk);
        load_stage = 1'b0;
    endtask

    // driver: reference model, push expectation, fire request
    task automatic run_case(input logic [7:0] v, input bit inject, input string tag);
        tte_t tm [0:TBL_LEN-1];
        exp_item_t it;
        int m, stop_at, k;
        apply_stage();
        for (int i = 0; i < TBL_LEN; i++)
            tm[i] = (i < BUF_N) ? tte_t'(st_bm[i]) : tte_t'(st_mem[BASE_ADDR + i]);
        m = -1;
        stop_at = TBL_LEN;
        for (int i = 0; i < TBL_LEN; i++) begin
            if (tm[i].tail) begin stop_at = i; break; end
            if (tm[i].vpn == v) begin m = i; break; end
        end
        if (m < 0) begin
            k = (stop_at < TBL_LEN) ? stop_at / 2 : (TBL_LEN - 1) / 2;
            it.flt = 1'b1;
            it.cyc = 16 + (k + 2) + 1;
            for (int i = 0; i < TBL_LEN; i++) exp_tbl[i] = tm[i];
            for (int i = 0; i < BUF_N; i++)   exp_bm[i]  = st_bm[i];
        end else begin
            it.flt = 1'b0;
            it.cyc = 16 + (m / 2 + 2) + ((m == 0) ? 1 : m + 2) + (BUF_N + 1) + 1;
            for (int i = 0; i < TBL_LEN; i++) exp_tbl[i] = tm[i];
            for (int i = 1; i <= m; i++)      exp_tbl[i] = tm[i - 1];
            exp_tbl[0] = tm[m];
            for (int i = 0; i < BUF_N; i++)   exp_bm[i]  = exp_tbl[i];
        end
        sq.push_back(it);
        n_exp++;
        miss_req = 1'b1;
        miss_vpn = v;
        @(negedge clk);
        miss_req = 1'b0;
        // R1: accepted request raises busy next cycle
        chk(busy == 1'b1, "R1", {tag, " busy after accept"}, int'(busy), 1);
        if (inject) begin
            repeat (4) @(negedge clk);
            miss_req = 1'b1;
            miss_vpn = 8'h12;
            @(negedge clk);
            miss_req = 1'b0;
        end
        wait (n_mon == n_exp);
        repeat (3) @(negedge clk);
        // R2: no second refill after completion
        chk(busy == 1'b0, "R2", {tag, " idle after completion"}, int'(busy), 0);
    endtask

    // monitor: pop expectation when the engine finishes and compare
    initial begin
        int run_len = 0;
        forever begin
            @(negedge clk);
            if (busy) run_len++;
            else      run_len = 0;
            if (done || fault) begin
                exp_item_t it;
                int mis;
                int first_bad;
                if (sq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected completion", 1, 0);
                end else begin
                    it = sq.pop_front();
                    // R7 R8: kind of completion
                    chk(fault == it.flt, it.flt ? "R8" : "R7", "completion kind fault",
                        int'(fault), int'(it.flt));
                    // R1: busy span equals refill length
                    chk(run_len == it.cyc, "R1", "busy span", run_len, it.cyc);
                    @(negedge clk);
                    run_len = 0;
                    // R9
                    chk(int'(last_cycles) == it.cyc, "R9", "last_cycles",
                        int'(last_cycles), it.cyc);
                    mis = 0; first_bad = -1;
                    for (int i = 0; i < TBL_LEN; i++)
                        if (mem[BASE_ADDR + i] !== exp_tbl[i]) begin
                            mis++;
                            if (first_bad < 0) first_bad = i;
                        end
                    // R3 R4 R5 R6: table image after the refill
                    chk(mis == 0, "R6", $sformatf("table image, first bad slot %0d", first_bad),
                        mis, 0);
                    mis = 0;
                    for (int i = 0; i < BUF_N; i++)
                        if (bm[i] !== exp_bm[i]) mis++;
                    // R7 R8: buffer contents
                    chk(mis == 0, it.flt ? "R8" : "R7", "buffer mismatches", mis, 0);
                    n_mon++;
                end
            end
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, n_exp);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        miss_req = 1'b0;
        miss_vpn = '0;
        setup_default();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10
        chk(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
        chk(fault == 1'b0, "R10", "fault after reset", int'(fault), 0);
        chk(last_cycles == '0, "R10", "last_cycles after reset", int'(last_cycles), 0);

        // R4 R6: odd slot deep in table
        setup_default();
        run_case(8'h19, 1'b0, "hit slot 25");
        // R3 R6: match at slot 0 from saved buffer
        setup_default();
        run_case(8'h80, 1'b0, "hit slot 0");
        // R3 R6: match at last saved slot
        setup_default();
        run_case(8'h8F, 1'b0, "hit slot 15");
        // R4: both slots of pair 10 match, lower wins
        setup_default();
        st_mem[BASE_ADDR + 20] = mk(1'b0, 8'h77, 8'h31);
        st_mem[BASE_ADDR + 21] = mk(1'b0, 8'h77, 8'h32);
        run_case(8'h77, 1'b0, "dual match pair");
        // R5 R8: page lies past an end mark
        setup_default();
        st_mem[BASE_ADDR + 30] = mk(1'b1, 8'h00, 8'h00);
        st_mem[BASE_ADDR + 32] = mk(1'b0, 8'h66, 8'h44);
        run_case(8'h66, 1'b0, "past end mark");
        // R5 R8: end-marked entry carrying the page
        setup_default();
        st_mem[BASE_ADDR + 22] = mk(1'b1, 8'h55, 8'h01);
        run_case(8'h55, 1'b0, "end entry holds page");
        // R3 R8: no end mark, page absent (stale head holds it)
        setup_default();
        run_case(8'hF0, 1'b0, "length exhausted");
        // R2: repeated request while busy
        setup_default();
        run_case(8'h19, 1'b1, "request while busy");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule